// File: doc/BRIEF.md
# Per-Pixel Gain and Offset Word Sequencer

This block sits between an image-processing controller and a set of per-channel correction stages. For every pixel the controller sends a gain word and an offset word for each colour channel, one word per clock, over a 10-bit parallel bus. The block counts the words of a pixel and steers each one into the matching gain or offset holding register. There are six such registers, one gain and one offset for each of the red, green and blue channels. The registers drive the downstream correction stages directly.

Two modes are supported. In colour mode all three channels are refreshed every pixel. In mono mode only the channel named by the channel select is refreshed, and that takes two words.

A start-of-pixel strobe realigns the word counter to the first slot. A write-enable freezes all six registers and pauses the counter, so a pixel can be spread across gaps in the enable. A one-cycle flag marks the completion of each pixel.

Top module: `pxcorr_seq`

## Requirements
- R1: While `wr_en` is high, exactly one word is captured on each rising clock edge, into the register chosen by the current slot. At most one register changes per cycle.
- R2: In colour mode (`mono_i`=0) slots 0 to 5 map, in that order, to red gain, red offset, green gain, green offset, blue gain and blue offset.
- R3: In mono mode (`mono_i`=1), `chan_sel_i` selects the channel: 0 is red, 1 is green, and 2 or 3 is blue. Slot 0 writes that channel's gain and slot 1 writes its offset. No other register changes.
- R4: While `wr_en` is low, no register changes, whatever the values on `word_i`, `sop_i` or the mode inputs.
- R5: When `sop_i` is high together with `wr_en`, the word of that same cycle goes to slot 0 and the next word goes to slot 1. When `sop_i` is high while `wr_en` is low, the next enabled word goes to slot 0.
- R6: Without a strobe, the counter wraps to slot 0 after slot 5 in colour mode and after slot 1 in mono mode.
- R7: `pix_done_o` is high for exactly the one cycle after the last slot of a pixel is captured. At all other times it is low.
- R8: A pixel interrupted by low `wr_en` resumes at the same slot when the enable returns.
- R9: A low `rst_n` clears all six registers, the counter and `pix_done_o` at once, without waiting for a clock. After `rst_n` rises, the block stays in reset for two more rising edges and ignores its inputs during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable; a low level freezes registers and counter |
| sop_i | input | 1 | Start-of-pixel strobe |
| mono_i | input | 1 | 0 = colour mode, 1 = mono mode |
| chan_sel_i | input | 2 | Channel refreshed in mono mode |
| word_i | input | 10 | Gain or offset word |
| r_gain_o | output | 10 | Red gain register |
| r_ofs_o | output | 10 | Red offset register |
| g_gain_o | output | 10 | Green gain register |
| g_ofs_o | output | 10 | Green offset register |
| b_gain_o | output | 10 | Blue gain register |
| b_ofs_o | output | 10 | Blue offset register |
| pix_done_o | output | 1 | One-cycle pixel-complete flag |

## Verification
The start-of-pixel strobe can land in the same cycle as a word capture. When it arrives mid-pixel, the realignment and the write must both act on that one word. The bench provokes this by raising the strobe on the fourth word of a colour pixel, and expects red gain, not green offset, to take that word. The bench also provokes a strobe during an enable gap and a strobe on the cycle right after a pixel completes. In both cases it judges the slot of the following word and the one-cycle width of the completion flag.

// File: rtl/pxcorr_pkg.sv
package pxcorr_pkg;
  localparam int unsigned NUM_CH       = 3;
  localparam int unsigned WORDS_PER_CH = 2;
  localparam int unsigned TRI_SLOTS    = NUM_CH * WORDS_PER_CH;
  localparam int unsigned SLOT_W       = $clog2(TRI_SLOTS);
  localparam int unsigned CH_W         = $clog2(NUM_CH);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [CH_W-1:0]   chan_t;

  typedef enum logic {
    MODE_TRI  = 1'b0,
    MODE_MONO = 1'b1
  } mode_e;

  typedef struct packed {
    logic  wr;
    chan_t ch;
    logic  is_ofs;
  } wsel_t;
endpackage

// File: rtl/pxcorr_rst_sync.sv
module pxcorr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pxcorr_slot_ctr.sv
module pxcorr_slot_ctr
  import pxcorr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  sop_i,
  input  mode_e mode_i,
  output slot_t eff_slot_o,
  output logic  done_o
);
  localparam slot_t LAST_TRI = slot_t'(TRI_SLOTS - 1);

  slot_t slot_q, slot_d;
  logic  done_q, done_d;
  logic  last_w;

  // next-state logic
  always_comb begin
    eff_slot_o = sop_i ? '0 : slot_q;
    if (mode_i == MODE_MONO) last_w = (eff_slot_o != '0);
    else                     last_w = (eff_slot_o == LAST_TRI);
    slot_d = slot_q;
    if (en_i)       slot_d = last_w ? '0 : eff_slot_o + slot_t'(1);
    else if (sop_i) slot_d = '0;
    done_d = en_i & last_w;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pxcorr_slot_dec.sv
module pxcorr_slot_dec
  import pxcorr_pkg::*;
(
  input  logic  en_i,
  input  mode_e mode_i,
  input  chan_t chan_sel_i,
  input  slot_t eff_slot_i,
  output wsel_t wsel_o
);
  localparam chan_t TOP_CH = chan_t'(NUM_CH - 1);

  always_comb begin
    wsel_o.wr = en_i;
    if (mode_i == MODE_MONO) begin
      wsel_o.ch     = (chan_sel_i > TOP_CH) ? TOP_CH : chan_sel_i;
      wsel_o.is_ofs = (eff_slot_i != '0);
    end else begin
      wsel_o.ch     = chan_t'(eff_slot_i / slot_t'(WORDS_PER_CH));
      wsel_o.is_ofs = eff_slot_i[0];
    end
  end
endmodule

// File: rtl/pxcorr_reg_bank.sv
module pxcorr_reg_bank
  import pxcorr_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  wsel_t                          wsel_i,
  input  logic [DATA_W-1:0]              word_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  gain_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  ofs_o
);
  logic [NUM_CH-1:0] ld_gain;
  logic [NUM_CH-1:0] ld_ofs;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] gain_q;
    logic [DATA_W-1:0] ofs_q;
    logic              hit;

    assign hit        = wsel_i.wr && (wsel_i.ch == chan_t'(c));
    assign ld_gain[c] = hit && !wsel_i.is_ofs;
    assign ld_ofs[c]  = hit &&  wsel_i.is_ofs;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gain_q <= '0;
      else if (ld_gain[c]) gain_q <= word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ofs_q <= '0;
      else if (ld_ofs[c]) ofs_q <= word_i;
    end

    assign gain_o[c] = gain_q;
    assign ofs_o[c]  = ofs_q;
  end
endmodule

// File: rtl/pxcorr_seq.sv
module pxcorr_seq
  import pxcorr_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sop_i,
  input  logic              mono_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] r_gain_o,
  output logic [DATA_W-1:0] r_ofs_o,
  output logic [DATA_W-1:0] g_gain_o,
  output logic [DATA_W-1:0] g_ofs_o,
  output logic [DATA_W-1:0] b_gain_o,
  output logic [DATA_W-1:0] b_ofs_o,
  output logic              pix_done_o
);
  logic  srst_n;
  mode_e mode;
  slot_t eff_slot;
  wsel_t wsel;
  logic [NUM_CH-1:0][DATA_W-1:0] gain_q;
  logic [NUM_CH-1:0][DATA_W-1:0] ofs_q;

  assign mode = mono_i ? MODE_MONO : MODE_TRI;

  pxcorr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst_n_o (srst_n)
  );

  pxcorr_slot_ctr slot_ctr_i (
    .clk        (clk),
    .rst_n      (srst_n),
    .en_i       (wr_en),
    .sop_i      (sop_i),
    .mode_i     (mode),
    .eff_slot_o (eff_slot),
    .done_o     (pix_done_o)
  );

  pxcorr_slot_dec slot_dec_i (
    .en_i       (wr_en),
    .mode_i     (mode),
    .chan_sel_i (chan_sel_i),
    .eff_slot_i (eff_slot),
    .wsel_o     (wsel)
  );

  pxcorr_reg_bank #(.DATA_W(DATA_W)) reg_bank_i (
    .clk    (clk),
    .rst_n  (srst_n),
    .wsel_i (wsel),
    .word_i (word_i),
    .gain_o (gain_q),
    .ofs_o  (ofs_q)
  );

  assign r_gain_o = gain_q[0];
  assign r_ofs_o  = ofs_q[0];
  assign g_gain_o = gain_q[1];
  assign g_ofs_o  = ofs_q[1];
  assign b_gain_o = gain_q[2];
  assign b_ofs_o  = ofs_q[2];
endmodule

// File: rtl/pxcorr_seq_chk.sv
module pxcorr_seq_chk #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              sop_i,
  input logic              mono_i,
  input logic [1:0]        chan_sel_i,
  input logic [DATA_W-1:0] word_i,
  input logic [DATA_W-1:0] r_gain_o,
  input logic [DATA_W-1:0] r_ofs_o,
  input logic [DATA_W-1:0] g_gain_o,
  input logic [DATA_W-1:0] g_ofs_o,
  input logic [DATA_W-1:0] b_gain_o,
  input logic [DATA_W-1:0] b_ofs_o,
  input logic              pix_done_o
);
  logic [6*DATA_W-1:0] all_regs;
  assign all_regs = {r_gain_o, r_ofs_o, g_gain_o, g_ofs_o, b_gain_o, b_ofs_o};

  // R4: a cycle without enable leaves every register untouched
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(all_regs));

  // R1: never more than one register written per edge
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({r_gain_o != $past(r_gain_o), r_ofs_o != $past(r_ofs_o),
                g_gain_o != $past(g_gain_o), g_ofs_o != $past(g_ofs_o),
                b_gain_o != $past(b_gain_o), b_ofs_o != $past(b_ofs_o)}) <= 1);

  // R3: mono mode with a non-red select leaves red alone
  p_mono_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mono_i && chan_sel_i != 2'd0) |=> ($stable(r_gain_o) && $stable(r_ofs_o)));

  // R5: strobe with enable puts the word into the first gain register
  p_sop_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sop_i && (!mono_i || chan_sel_i == 2'd0)) |=> (r_gain_o == $past(word_i)));

  // R7: completion flag is a single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_done_o |=> !pix_done_o);

  // R7: completion needs a capture in the previous cycle
  p_done_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_done_o) |-> $past(wr_en));

  // R9: while held in reset every output reads zero
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |-> (all_regs == '0 && !pix_done_o));
endmodule

bind pxcorr_seq pxcorr_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (srst_n),
  .wr_en      (wr_en),
  .sop_i      (sop_i),
  .mono_i     (mono_i),
  .chan_sel_i (chan_sel_i),
  .word_i     (word_i),
  .r_gain_o   (r_gain_o),
  .r_ofs_o    (r_ofs_o),
  .g_gain_o   (g_gain_o),
  .g_ofs_o    (g_ofs_o),
  .b_gain_o   (b_gain_o),
  .b_ofs_o    (b_ofs_o),
  .pix_done_o (pix_done_o)
);

// File: tb/pxcorr_seq_tb_top.sv
`timescale 1ns/1ps
module pxcorr_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       sop_i;
  logic       mono_i;
  logic [1:0] chan_sel_i;
  logic [9:0] word_i;
  logic [9:0] r_gain_o, r_ofs_o, g_gain_o, g_ofs_o, b_gain_o, b_ofs_o;
  logic       pix_done_o;

  int vec_cnt  = 0;
  int err_cnt  = 0;
  bit finished = 0;

  // reference model state, built from the requirements
  int         m_slot;
  logic [9:0] e_gain [3];
  logic [9:0] e_ofs  [3];
  logic       e_done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  pxcorr_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sop_i      (sop_i),
    .mono_i     (mono_i),
    .chan_sel_i (chan_sel_i),
    .word_i     (word_i),
    .r_gain_o   (r_gain_o),
    .r_ofs_o    (r_ofs_o),
    .g_gain_o   (g_gain_o),
    .g_ofs_o    (g_ofs_o),
    .b_gain_o   (b_gain_o),
    .b_ofs_o    (b_ofs_o),
    .pix_done_o (pix_done_o)
  );

  function automatic logic [9:0] val(input int p, input int k);
    return 10'((p * 97 + k * 211 + 5) % 1024);
  endfunction

  task automatic cmp(input string tag, input string nm, input logic [9:0] act, input logic [9:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
      bad = 1;
    end
  endtask

  task automatic check_all(input string tag);
    bit bad = 0;
    vec_cnt++;
    cmp(tag, "r_gain", r_gain_o, e_gain[0], bad);
    cmp(tag, "r_ofs",  r_ofs_o,  e_ofs[0],  bad);
    cmp(tag, "g_gain", g_gain_o, e_gain[1], bad);
    cmp(tag, "g_ofs",  g_ofs_o,  e_ofs[1],  bad);
    cmp(tag, "b_gain", b_gain_o, e_gain[2], bad);
    cmp(tag, "b_ofs",  b_ofs_o,  e_ofs[2],  bad);
    cmp(tag, "pix_done", {9'd0, pix_done_o}, {9'd0, e_done}, bad);
    if (bad) err_cnt++;
  endtask

  task automatic model_clear();
    m_slot = 0;
    e_done = 1'b0;
    for (int c = 0; c < 3; c++) begin
      e_gain[c] = '0;
      e_ofs[c]  = '0;
    end
  endtask

  // one clock of stimulus, model update, and check after the edge
  task automatic push(input bit en, input bit sop, input bit mono, input int sel,
                      input logic [9:0] w, input string tag);
    int  eff;
    bit  last;
    int  ch;
    bit  ofs;
    @(negedge clk);
    wr_en = en; sop_i = sop; mono_i = mono; chan_sel_i = 2'(sel); word_i = w;
    eff  = sop ? 0 : m_slot;
    last = mono ? (eff != 0) : (eff == 5);
    if (en) begin
      if (mono) begin
        ch  = (sel > 2) ? 2 : sel;
        ofs = (eff != 0);
      end else begin
        ch  = eff / 2;
        ofs = (eff % 2) == 1;
      end
      if (ofs) e_ofs[ch] = w;
      else     e_gain[ch] = w;
      m_slot = last ? 0 : eff + 1;
      e_done = last;
    end else begin
      if (sop) m_slot = 0;
      e_done = 1'b0;
    end
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    check_all("R9 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b1; sop_i = 1'b1; mono_i = 1'b0; word_i = 10'h155;
    repeat (2) @(posedge clk);
    #1;
    check_all("R9 release ignores inputs");
    @(negedge clk);
    wr_en = 1'b0; sop_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired actual=running expected=done");
      err_cnt++;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; sop_i = 1'b0; mono_i = 1'b0;
    chan_sel_i = 2'd0; word_i = '0;
    model_clear();
    #12;
    check_all("R9 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2/R8: colour pixels with enable gaps inside
    for (int p = 0; p < 40; p++) begin
      for (int k = 0; k < 6; k++) begin
        if (k == p % 6 && p % 4 != 0)
          for (int g = 0; g <= p % 3; g++) push(0, 0, 0, 0, ~val(p, k), "R8 gap");
        push(1, k == 0, 0, 0, val(p, k), "R2 colour order");
      end
    end
    // R4: strobe and mode toggles while disabled
    for (int g = 0; g < 4; g++) push(0, g[0], g[1], g, 10'h3ff, "R4 hold");

    // R6: colour wrap without strobe
    push(1, 1, 0, 0, val(50, 0), "R6 colour wrap");
    for (int k = 1; k < 18; k++) push(1, 0, 0, 0, val(50, k), "R6 colour wrap");

    // R3: mono sweep over all selects
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 10; p++)
        for (int k = 0; k < 2; k++) push(1, k == 0, 1, s, val(p + 60, k + s), "R3 mono");
      for (int k = 0; k < 5; k++) push(1, 0, 1, s, val(s, k + 9), "R6 mono wrap");
    end

    // R5: strobe mid-pixel in the same cycle as a capture
    push(1, 1, 0, 0, 10'd11, "R5 sop");
    push(1, 0, 0, 0, 10'd22, "R5 sop");
    push(1, 0, 0, 0, 10'd33, "R5 sop");
    push(1, 1, 0, 0, 10'd44, "R5 sop mid-pixel");
    for (int k = 1; k < 6; k++) push(1, 0, 0, 0, 10'(100 + k), "R5 after realign");
    // R5/R7: strobe right after completion, then strobe during a gap
    push(1, 1, 0, 0, 10'd7, "R7 sop after done");
    push(1, 0, 0, 0, 10'd8, "R5");
    push(0, 1, 0, 0, 10'd9, "R5 sop while disabled");
    push(1, 0, 0, 0, 10'd10, "R5 resume at slot 0");
    push(1, 0, 0, 0, 10'd12, "R1");

    // R9: reset in the middle of a pixel
    push(1, 0, 0, 0, 10'd300, "R1");
    do_reset();
    push(1, 0, 0, 0, 10'd501, "R9 counter at slot 0");
    push(1, 0, 0, 0, 10'd502, "R1");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule